// File: doc/BRIEF.md
# Decoder Event Interrupt Generator

This block turns status strobes from a sector decoding pipeline into three sticky, maskable interrupt flags and one combined interrupt line. The error flag merges two separate failure paths. The first is an uncorrectable result from the error-correction stage. The second is a failed check-sum stage that follows a successful correction.

The buffer flag does not follow a level. It fires on two specific changes of a 2-bit transfer-state input: leaving an active buffer fill to look for the next data, and finding that data so a transfer starts. The sector-ready flag fires once per completed sector decode.

Software uses a small register port. At address 0 it reads the raw flags and clears them by writing 1 to a bit. At address 1 it reads and writes the per-flag enable mask. The flag bit order is error = bit 0, buffer = bit 1, sector-ready = bit 2.

Top module: `dec_irq_gen`

## Requirements
- R1: After reset all flags are 0, the enable mask is 0, `reg_rdata_o` reads 0 at both addresses, and all interrupt outputs are low.
- R2: A cycle with `ecc_valid_i`=1 and `ecc_fail_i`=1 sets flag bit 0 at the next clock edge.
- R3: A cycle with `edc_valid_i`=1 and `edc_fail_i`=1 sets flag bit 0 only if the most recent correction result was a pass. That result must have been reported in an earlier cycle and not yet consumed by a check-sum result. Any check-sum result consumes the pass. A correction result arriving in the same cycle as a check-sum result replaces the stored pass for later check-sum results.
- R4: Flag bit 1 is set when `xfer_state_i` was 1 (filling buffer) on the previous clock edge and is 2 (searching) now. The state captured at reset is 0 (idle).
- R5: Flag bit 1 is set when `xfer_state_i` moves from 2 (searching) to 3 (transfer start). No other transition, and no held state, sets it.
- R6: Each cycle with `sector_done_i`=1 sets flag bit 2.
- R7: A flag stays set until a write to address 0 has 1 in that bit. Writing 0 to a bit, or writing to address 1, leaves the flags unchanged.
- R8: If an event for a bit arrives in the same cycle as a write-1 clear of that bit, the flag ends up set.
- R9: `err_irq_o`, `buf_irq_o` and `rdy_irq_o` equal their flag ANDed with the enable bit written at address 1. Flags are set and readable whatever their enable.
- R10: `irq_o` is high exactly when at least one flag is both set and enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ecc_valid_i | input | 1 | Correction result strobe |
| ecc_fail_i | input | 1 | Correction result is uncorrectable |
| edc_valid_i | input | 1 | Check-sum result strobe |
| edc_fail_i | input | 1 | Check-sum mismatch |
| sector_done_i | input | 1 | One sector fully decoded |
| xfer_state_i | input | 2 | Buffer transfer state: 0 idle, 1 filling, 2 searching, 3 start |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 1 | 0 flags (write 1 to clear), 1 enable mask |
| reg_wdata_i | input | 3 | Write data |
| reg_rdata_o | output | 3 | Read data for `reg_addr_i`, combinational |
| err_irq_o | output | 1 | Error interrupt |
| buf_irq_o | output | 1 | Buffer activity interrupt |
| rdy_irq_o | output | 1 | Sector ready interrupt |
| irq_o | output | 1 | Combined interrupt |

## Verification
A stale copy of the transfer state would show as a buffer interrupt that fires one cycle late, or on the wrong pair of states. The bench compares every cycle, so this fault appears within a cycle of the transition. A wrong stored correction result would show as an error flag after a failed correction followed by a failed check-sum, or a missing one after a pass. Either appears at the edge after the check-sum strobe. Clear-versus-set priority faults show on the first cycle where a clear and an event of the same bit coincide, which directed steps force early.

// File: rtl/dec_irq_pkg.sv
package dec_irq_pkg;
  localparam int unsigned NSRC   = 3;
  localparam int unsigned SW     = 2;
  localparam int unsigned SRC_ERR = 0;
  localparam int unsigned SRC_BUF = 1;
  localparam int unsigned SRC_RDY = 2;

  typedef enum logic [SW-1:0] {
    XS_IDLE   = 2'd0,
    XS_FILL   = 2'd1,
    XS_SEARCH = 2'd2,
    XS_START  = 2'd3
  } xfer_state_e;

  typedef logic [NSRC-1:0] src_vec_t;
endpackage

// File: rtl/dec_irq_err_det.sv
module dec_irq_err_det (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ecc_valid_i,
  input  logic ecc_fail_i,
  input  logic edc_valid_i,
  input  logic edc_fail_i,
  output logic evt_o
);
  logic ecc_ok_q;

  // last correction passed and no check-sum result has consumed it yet
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          ecc_ok_q <= 1'b0;
    else if (ecc_valid_i) ecc_ok_q <= !ecc_fail_i;
    else if (edc_valid_i) ecc_ok_q <= 1'b0;
  end

  logic ecc_bad, edc_bad;
  assign ecc_bad = ecc_valid_i && ecc_fail_i;
  assign edc_bad = edc_valid_i && edc_fail_i && ecc_ok_q;
  assign evt_o   = ecc_bad || edc_bad;

  p_edc_needs_pass_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (edc_valid_i && !ecc_valid_i) |=> !ecc_ok_q);
endmodule

// File: rtl/dec_irq_buf_det.sv
module dec_irq_buf_det
  import dec_irq_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [SW-1:0] state_i,
  output logic          evt_o
);
  xfer_state_e prev_q, cur;

  assign cur = xfer_state_e'(state_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= XS_IDLE;
    else         prev_q <= cur;
  end

  logic fill_done, found;
  assign fill_done = (prev_q == XS_FILL)   && (cur == XS_SEARCH);
  assign found     = (prev_q == XS_SEARCH) && (cur == XS_START);
  assign evt_o     = fill_done || found;

  p_held_quiet_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cur == prev_q) |-> !evt_o);
endmodule

// File: rtl/dec_irq_flags.sv
module dec_irq_flags
  import dec_irq_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  src_vec_t evt_i,
  input  src_vec_t clr_i,
  input  logic     en_we_i,
  input  src_vec_t en_d_i,
  output src_vec_t flag_o,
  output src_vec_t en_o
);
  src_vec_t en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      en_q <= '0;
    else if (en_we_i) en_q <= en_d_i;
  end
  assign en_o = en_q;

  for (genvar i = 0; i < NSRC; i++) begin : g_flag
    logic flag_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       flag_q <= 1'b0;
      else if (evt_i[i]) flag_q <= 1'b1;   // set beats clear
      else if (clr_i[i]) flag_q <= 1'b0;
    end
    assign flag_o[i] = flag_q;

    p_set_wins_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      evt_i[i] |=> flag_q);
    p_sticky_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (flag_q && !clr_i[i]) |=> flag_q);
    p_clear_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clr_i[i] && !evt_i[i]) |=> !flag_q);
  end
endmodule

// File: rtl/dec_irq_gen.sv
module dec_irq_gen
  import dec_irq_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ecc_valid_i,
  input  logic          ecc_fail_i,
  input  logic          edc_valid_i,
  input  logic          edc_fail_i,
  input  logic          sector_done_i,
  input  logic [SW-1:0] xfer_state_i,
  input  logic          reg_we_i,
  input  logic          reg_addr_i,
  input  logic [NSRC-1:0] reg_wdata_i,
  output logic [NSRC-1:0] reg_rdata_o,
  output logic          err_irq_o,
  output logic          buf_irq_o,
  output logic          rdy_irq_o,
  output logic          irq_o
);
  localparam logic ADDR_FLAG = 1'b0;
  localparam logic ADDR_EN   = 1'b1;

  logic     err_evt, buf_evt;
  src_vec_t evt, clr, flag, en, act;

  dec_irq_err_det u_err (
    .clk_i, .rst_ni,
    .ecc_valid_i, .ecc_fail_i, .edc_valid_i, .edc_fail_i,
    .evt_o(err_evt)
  );

  dec_irq_buf_det u_buf (
    .clk_i, .rst_ni,
    .state_i(xfer_state_i),
    .evt_o  (buf_evt)
  );

  always_comb begin
    evt          = '0;
    evt[SRC_ERR] = err_evt;
    evt[SRC_BUF] = buf_evt;
    evt[SRC_RDY] = sector_done_i;
  end

  assign clr = (reg_we_i && reg_addr_i == ADDR_FLAG) ? reg_wdata_i : '0;

  dec_irq_flags u_flags (
    .clk_i, .rst_ni,
    .evt_i  (evt),
    .clr_i  (clr),
    .en_we_i(reg_we_i && reg_addr_i == ADDR_EN),
    .en_d_i (reg_wdata_i),
    .flag_o (flag),
    .en_o   (en)
  );

  assign act         = flag & en;
  assign err_irq_o   = act[SRC_ERR];
  assign buf_irq_o   = act[SRC_BUF];
  assign rdy_irq_o   = act[SRC_RDY];
  assign irq_o       = |act;
  assign reg_rdata_o = (reg_addr_i == ADDR_EN) ? en : flag;

  p_ecc_fail_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ecc_valid_i && ecc_fail_i) |=> flag[SRC_ERR]);
  p_done_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sector_done_i |=> flag[SRC_RDY]);
  p_mask_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en[SRC_BUF] |-> !buf_irq_o);
  p_line_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (err_irq_o || buf_irq_o || rdy_irq_o));
endmodule

// File: tb/dec_irq_gen_bench.sv
module dec_irq_gen_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic ecc_v, ecc_f, edc_v, edc_f, done, we, addr;
  logic [1:0] st;
  logic [2:0] wd, rd;
  logic err_o, buf_o, rdy_o, irq;

  dec_irq_gen u_dec_irq_gen (
    .clk_i(clk), .rst_ni(rst_n),
    .ecc_valid_i(ecc_v), .ecc_fail_i(ecc_f),
    .edc_valid_i(edc_v), .edc_fail_i(edc_f),
    .sector_done_i(done), .xfer_state_i(st),
    .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wd),
    .reg_rdata_o(rd),
    .err_irq_o(err_o), .buf_irq_o(buf_o), .rdy_irq_o(rdy_o), .irq_o(irq)
  );

  int n_chk = 0, n_bad = 0;
  logic [2:0] m_flag, m_en;
  logic [1:0] m_prev;
  logic       m_ok;

  task automatic chk(input string tag, input logic [2:0] act, input logic [2:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  function automatic logic [2:0] next_flag(
    input logic [2:0] f, input logic ev, input logic ef, input logic dv,
    input logic df, input logic dn, input logic [1:0] s, input logic w,
    input logic a, input logic [2:0] d);
    logic [2:0] e, c;
    e[0] = (ev && ef) || (dv && df && m_ok);
    e[1] = (m_prev == 2'd1 && s == 2'd2) || (m_prev == 2'd2 && s == 2'd3);
    e[2] = dn;
    c    = (w && !a) ? d : 3'b000;
    return (f & ~c) | e;
  endfunction

  // drive at negedge, check combinational read, advance model at posedge,
  // then check registered outputs at the following negedge
  task automatic step(input logic ev, input logic ef, input logic dv,
                      input logic df, input logic dn, input logic [1:0] s,
                      input logic w, input logic a, input logic [2:0] d);
    logic [2:0] nf;
    ecc_v = ev; ecc_f = ef; edc_v = dv; edc_f = df; done = dn; st = s;
    we = w; addr = a; wd = d;
    #1;
    chk("R7 rdata", rd, a ? m_en : m_flag);
    nf = next_flag(m_flag, ev, ef, dv, df, dn, s, w, a, d);
    if (w && a) m_en = d;
    if (ev) m_ok = !ef; else if (dv) m_ok = 1'b0;
    m_prev = s;
    m_flag = nf;
    @(negedge clk);
    chk("R2/R3 err_irq", {2'b0, err_o}, {2'b0, m_flag[0] & m_en[0]});
    chk("R4/R5 buf_irq", {2'b0, buf_o}, {2'b0, m_flag[1] & m_en[1]});
    chk("R6 rdy_irq",    {2'b0, rdy_o}, {2'b0, m_flag[2] & m_en[2]});
    chk("R10 irq",       {2'b0, irq},   {2'b0, |(m_flag & m_en)});
  endtask

  task automatic rd_flags(input string tag, input logic [2:0] exp);
    we = 0; addr = 0; #1; chk(tag, rd, exp);
  endtask

  initial begin
    #200000;
    n_bad++;
    $display("FAIL watchdog expired actual=timeout expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'hC0DE));
    ecc_v = 0; ecc_f = 0; edc_v = 0; edc_f = 0; done = 0; st = 0;
    we = 0; addr = 0; wd = 0;
    m_flag = 0; m_en = 0; m_prev = 0; m_ok = 0;
    repeat (3) @(negedge clk);
    #1;
    chk("R1 flags", rd, 3'b000);
    chk("R1 irq", {err_o, buf_o, irq}, 3'b000);
    rst_n = 1'b1;
    @(negedge clk);
    addr = 1; #1; chk("R1 enable", rd, 3'b000);

    // R9: flags latch with enables off
    step(1,1,0,0,1,0, 0,0,0);
    rd_flags("R2 ecc fail flag", 3'b101);
    chk("R9 masked", {err_o, rdy_o, irq}, 3'b000);
    step(0,0,0,0,0,0, 1,1,3'b111);
    chk("R9 enabled", {err_o, rdy_o, irq}, 3'b111);
    // R7: write 0 and write to enable do not clear
    step(0,0,0,0,0,0, 1,0,3'b000);
    rd_flags("R7 write0 keeps", 3'b101);
    step(0,0,0,0,0,0, 1,0,3'b101);
    rd_flags("R7 w1c", 3'b000);
    // R3: edc fail after ecc fail -> no new flag beyond the ecc one
    step(1,1,0,0,0,0, 0,0,0);
    step(0,0,0,0,0,0, 1,0,3'b001);
    step(0,0,1,1,0,0, 0,0,0);
    rd_flags("R3 edc after ecc fail", 3'b000);
    step(1,0,0,0,0,0, 0,0,0);
    step(0,0,1,1,0,0, 0,0,0);
    rd_flags("R3 edc after ecc pass", 3'b001);
    step(0,0,0,0,0,0, 1,0,3'b001);
    step(0,0,1,1,0,0, 0,0,0);
    rd_flags("R3 pass consumed", 3'b000);
    // R4/R5 transitions
    step(0,0,0,0,0,1, 0,0,0);
    step(0,0,0,0,0,2, 0,0,0);
    rd_flags("R4 fill->search", 3'b010);
    step(0,0,0,0,0,2, 1,0,3'b010);
    rd_flags("R5 held search", 3'b000);
    step(0,0,0,0,0,3, 0,0,0);
    rd_flags("R5 search->start", 3'b010);
    step(0,0,0,0,0,1, 1,0,3'b010);
    step(0,0,0,0,0,3, 0,0,0);
    rd_flags("R5 fill->start quiet", 3'b000);
    // R8: event and clear together
    step(0,0,0,0,1,3, 1,0,3'b100);
    rd_flags("R8 set wins", 3'b100);

    for (int i = 0; i < 3000; i++) begin
      logic ev, dv, w;
      ev = ($urandom % 4) == 0;
      dv = ($urandom % 4) == 0;
      w  = ($urandom % 4) == 0;
      step(ev, 1'($urandom), dv, 1'($urandom), ($urandom % 8) == 0,
           2'($urandom), w, 1'($urandom), 3'($urandom));
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule